// File: doc/BRIEF.md
# Bordered Raster Display Timing Generator

This block produces the raster timing for a video output whose visible picture is an outer border area that frames an inner display window. A horizontal counter and a vertical counter run freely through a programmable line length and field length. The block decodes the border and window regions from them and drives the sync outputs. It issues frame-buffer fetch requests with word addresses for the window. It chooses the output colour from the incoming pixel data, a programmable border colour or black.

A host writes twelve 32-bit configuration words. Each write lands in a shadow copy. The whole shadow set is copied into the active set on the last clock of a field, so it governs the field that starts on the next clock. Changes to the mode, the base address or the blank bit therefore never tear a picture. The block supports interlaced scanning with a start line and a base address for each field, scanline doubling, horizontal pixel doubling, and several pixel depths. Pixel data arrives on a plain valid/data input that is sampled in the same cycle as the window position it belongs to.

Top module: `raster_border_timer`

## Requirements
- R1: After reset, the active configuration word 0 holds the DEF_HTOTAL/DEF_VTOTAL totals and every other word is zero. Both counters are zero, and hsync, vsync, in_border, in_window, fetch_req and rgb are all low.
- R2: Word 0 bits 15:0 give the clocks per line and bits 31:16 the lines per field. The horizontal position counts 0 to total-1 and then wraps, and the line count advances on each wrap.
- R3: Word 10 bit 8 enables video. While it is set, hsync is high for positions below HSYNC_CLKS and vsync is high for lines below VSYNC_LINES. While it is clear, both syncs are low and rgb is zero.
- R4: A host write to word index 0 to 11 changes only the shadow copy. All shadow words become active together at the first clock of the next field.
- R5: in_border is high when the position lies in [word1[31:16], word1[15:0]) and the line lies in [word2[31:16], word2[15:0]).
- R6: The window starts at the position in word 4 bits 15:0. It spans (word3[9:0]+1) words, and each word occupies 2^s clocks. s is 2, 1, 0 or 0 for depth code word9[3:2] = 0, 1, 2 or 3, plus 1 when low resolution (word8 bit 0) is set.
- R7: The first window line is word5[31:16] in field 0 and word5[15:0] in field 1; a start of 0 opens no window. The window lasts word3[19:10]+1 source lines, and each line is shown twice when word9 bit 1 is set. in_window also needs display enable (word9 bit 0).
- R8: fetch_req pulses in the first clock of each window word. Its address is the line base plus the word index. The line base starts at word6 (field 0) or word7 (field 1) and grows by (width words - 1) + modulo (word3[29:20]) after each source line.
- R9: Word 10 bit 4 selects interlace. field_odd then toggles at every field start; without interlace it is 0.
- R10: Blank (word8 bit 3) suppresses fetches and window pixels, so the border colour covers the whole border area.
- R11: rgb is pix_data in the window when not blanked and pix_valid is high. Otherwise it is the border colour word11[23:0] inside the border, and 0 elsewhere.
- R12: pix_x2 reflects word9 bit 23, the doubled-pixel-clock select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Configuration word index |
| host_wdata | input | 32 | Host write data |
| pix_valid | input | 1 | Pixel data valid |
| pix_data | input | 24 | Pixel colour from the fetch path |
| fetch_req | output | 1 | Fetch request for one window word |
| fetch_addr | output | AW | Word address of the fetch |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| in_border | output | 1 | Position lies in the border area |
| in_window | output | 1 | Position lies in the display window |
| field_odd | output | 1 | Current field (1 = second field) |
| pix_x2 | output | 1 | Doubled pixel clock selected |
| rgb | output | 24 | Output colour |

## Verification
Every output is a combinational decode of the registered counters and active configuration, so each result is due in the same cycle in which the counters reach the position. A host write is due only at the first clock after the current field ends. The bench keeps its own position counters and its own shadow and active copies, which it updates at the rising edge in the same order as the rules. It compares every output at the falling edge after that update. Directed checks probe a border change just before and just after the field boundary.

// File: rtl/raster_border_timer.sv
module raster_border_timer #(
  parameter int AW          = 24,
  parameter int DEF_HTOTAL  = 857,
  parameter int DEF_VTOTAL  = 262,
  parameter int HSYNC_CLKS  = 64,
  parameter int VSYNC_LINES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [3:0]    host_addr,
  input  logic [31:0]   host_wdata,
  input  logic          pix_valid,
  input  logic [23:0]   pix_data,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  output logic          hsync,
  output logic          vsync,
  output logic          in_border,
  output logic          in_window,
  output logic          field_odd,
  output logic          pix_x2,
  output logic [23:0]   rgb
);
  localparam int NREG = 12;
  localparam logic [31:0] SYNC_RST = {16'(DEF_VTOTAL), 16'(DEF_HTOTAL)};

  logic [31:0]   shd [NREG];
  logic [31:0]   act [NREG];
  logic [15:0]   h, v;
  logic          field, row_on, rep;
  logic [9:0]    row;
  logic [AW-1:0] line_base;

  wire [15:0] htot = act[0][15:0];
  wire [15:0] vtot = act[0][31:16];
  wire h_end = ({1'b0, h} + 17'd1) >= {1'b0, htot};
  wire v_end = ({1'b0, v} + 17'd1) >= {1'b0, vtot};

  wire [9:0]  ww   = act[3][9:0];
  wire [9:0]  wh   = act[3][19:10];
  wire [9:0]  wmod = act[3][29:20];
  wire [15:0] whs  = act[4][15:0];
  wire [15:0] wvs  = field ? act[5][15:0] : act[5][31:16];
  wire [AW-1:0] base = field ? act[7][AW-1:0] : act[6][AW-1:0];
  wire lowres  = act[8][0];
  wire blank   = act[8][3];
  wire disp_en = act[9][0];
  wire ldbl    = act[9][1];
  wire [1:0] bpc = act[9][3:2];
  wire vid_en  = act[10][8];

  wire [2:0]  sh   = (bpc == 2'd0 ? 3'd2 : bpc == 2'd1 ? 3'd1 : 3'd0) + {2'b0, lowres};
  wire [15:0] col  = h - whs;
  wire [19:0] span = {9'b0, {1'b0, ww} + 11'd1} << sh;
  wire col_on = (h >= whs) && ({4'b0, col} < span);
  wire [15:0] word  = col >> sh;
  wire        slot0 = (col & ((16'd1 << sh) - 16'd1)) == 16'd0;

  assign in_window  = row_on & col_on & disp_en;
  assign fetch_req  = in_window & ~blank & slot0;
  assign fetch_addr = line_base + AW'(word);
  assign hsync      = vid_en & (h < 16'(HSYNC_CLKS));
  assign vsync      = vid_en & (v < 16'(VSYNC_LINES));
  assign in_border  = (h >= act[1][31:16]) && (h < act[1][15:0]) &&
                      (v >= act[2][31:16]) && (v < act[2][15:0]);
  assign rgb        = !vid_en ? 24'd0 :
                      (in_window & ~blank & pix_valid) ? pix_data :
                      in_border ? act[11][23:0] : 24'd0;
  assign field_odd  = field;
  assign pix_x2     = act[9][23];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shd[i] <= (i == 0) ? SYNC_RST : 32'd0;
    end else if (host_we && host_addr < 4'(NREG)) begin
      shd[host_addr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) act[i] <= (i == 0) ? SYNC_RST : 32'd0;
      h <= '0;
      v <= '0;
      field <= 1'b0;
      row_on <= 1'b0;
      rep <= 1'b0;
      row <= '0;
      line_base <= '0;
    end else if (h_end) begin
      h <= '0;
      if (v_end) begin
        v <= '0;
        act <= shd;
        field <= shd[10][4] & ~field;
        row_on <= 1'b0;
      end else begin
        v <= v + 16'd1;
        if (row_on) begin
          if (ldbl && !rep) begin
            rep <= 1'b1;
          end else begin
            rep <= 1'b0;
            if (row == wh) row_on <= 1'b0;
            else begin
              row <= row + 10'd1;
              line_base <= line_base + AW'(ww) + AW'(wmod);
            end
          end
        end else if (wvs != 16'd0 && v + 16'd1 == wvs) begin
          row_on <= 1'b1;
          row <= '0;
          rep <= 1'b0;
          line_base <= base;
        end
      end
    end else begin
      h <= h + 16'd1;
    end
  end
endmodule

module raster_border_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] h,
  input logic [15:0] v,
  input logic [15:0] htot,
  input logic        field,
  input logic        fetch_req,
  input logic        in_window,
  input logic        blank
);
  wire h_last = ({1'b0, h} + 17'd1) >= {1'b0, htot};

  a_r2_hwrap: assert property (@(posedge clk) disable iff (!rst_n)
    h_last |=> h == 16'd0);
  a_r2_hstep: assert property (@(posedge clk) disable iff (!rst_n)
    !h_last |=> h == $past(h) + 16'd1);
  a_r8_fetch_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> in_window);
  a_r9_field_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !(h == 16'd0 && v == 16'd0) |-> $stable(field));
  a_r10_blank_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !fetch_req);
endmodule

bind raster_border_timer raster_border_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h(h), .v(v), .htot(act[0][15:0]), .field(field),
  .fetch_req(fetch_req), .in_window(in_window), .blank(act[8][3])
);

// File: tb/test_raster_border_timer.sv
`timescale 1ns/1ps
module test_raster_border_timer;
  localparam int AW = 24, HT0 = 48, VT0 = 24, HS = 6, VS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic fetch_req, hsync, vsync, in_border, in_window, field_odd, pix_x2;
  logic [AW-1:0] fetch_addr;
  logic [23:0] rgb;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  raster_border_timer #(.AW(AW), .DEF_HTOTAL(HT0), .DEF_VTOTAL(VT0),
    .HSYNC_CLKS(HS), .VSYNC_LINES(VS)) i_raster_border_timer (.*);

  always #4 clk = ~clk;

  logic [31:0] msh [12];
  logic [31:0] mact [12];
  int mh, mv, mht, mvt;
  bit mf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) begin
        msh[i] = (i == 0) ? {16'(VT0), 16'(HT0)} : 32'd0;
        mact[i] = msh[i];
      end
      mh = 0; mv = 0; mf = 0;
    end else begin
      mht = int'(mact[0][15:0]);
      mvt = int'(mact[0][31:16]);
      if (mh + 1 >= mht) begin
        mh = 0;
        if (mv + 1 >= mvt) begin
          mv = 0;
          for (int i = 0; i < 12; i++) mact[i] = msh[i];
          mf = msh[10][4] & ~mf;
        end else mv++;
      end else mh++;
      if (host_we && host_addr < 12) msh[host_addr] = host_wdata;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at h=%0d v=%0d: got %0h expected %0h", tag, what, mh, mv, got, exp);
    end
  endtask

  task automatic check_all();
    int ww, wh, md, whs, vs, sh, span, c, r, nl, bpc;
    bit vid, en, blank, ld, lr, e_win, e_bord, e_fetch;
    longint addr;
    logic [23:0] e_rgb;
    vid = mact[10][8]; en = mact[9][0]; blank = mact[8][3];
    ld = mact[9][1]; lr = mact[8][0]; bpc = int'(mact[9][3:2]);
    ww = int'(mact[3][9:0]); wh = int'(mact[3][19:10]); md = int'(mact[3][29:20]);
    whs = int'(mact[4][15:0]);
    vs = mf ? int'(mact[5][15:0]) : int'(mact[5][31:16]);
    sh = (bpc == 0 ? 2 : bpc == 1 ? 1 : 0) + int'(lr);
    span = (ww + 1) << sh;
    c = mh - whs;
    r = mv - vs;
    nl = (wh + 1) << ld;
    e_bord = mh >= int'(mact[1][31:16]) && mh < int'(mact[1][15:0]) &&
             mv >= int'(mact[2][31:16]) && mv < int'(mact[2][15:0]);
    e_win = en && vs != 0 && r >= 0 && r < nl && c >= 0 && c < span;
    e_fetch = e_win && !blank && (c % (1 << sh)) == 0;
    e_rgb = !vid ? 24'd0 : (e_win && !blank && pix_valid) ? pix_data :
            e_bord ? mact[11][23:0] : 24'd0;
    chk("R2 R3", "hsync", 32'(hsync), 32'(vid && mh < HS));
    chk("R2 R3", "vsync", 32'(vsync), 32'(vid && mv < VS));
    chk("R5", "in_border", 32'(in_border), 32'(e_bord));
    chk("R6 R7", "in_window", 32'(in_window), 32'(e_win));
    chk("R8 R10", "fetch_req", 32'(fetch_req), 32'(e_fetch));
    if (e_fetch) begin
      addr = (mf ? longint'(mact[7][AW-1:0]) : longint'(mact[6][AW-1:0])) +
             longint'(r >> ld) * longint'(ww + md) + longint'(c >> sh);
      chk("R8", "fetch_addr", 32'(fetch_addr), 32'(addr & 64'hFFFFFF));
    end
    chk("R10 R11", "rgb", 32'(rgb), 32'(e_rgb));
    chk("R9", "field_odd", 32'(field_odd), 32'(mf));
    chk("R12", "pix_x2", 32'(pix_x2), 32'(mact[9][23]));
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (rst_n) check_all();
    pix_valid = 1'($urandom);
    pix_data = 24'($urandom);
    host_we = 1'b0;
  endtask

  task automatic wr(int idx, logic [31:0] d);
    host_we = 1'b1; host_addr = 4'(idx); host_wdata = d;
    tick();
  endtask

  task automatic next_frame();
    do tick(); while (!(mh == 0 && mv == 0));
  endtask

  task automatic cfg(int ht, int vt, int hbs, int hbe, int vbs, int vbe,
                     int w, int hgt, int md, int whs, int vs0, int vs1,
                     int b0, int b1, bit lr, bit blank, bit en, bit ld,
                     int bpc, bit x2, bit vid, bit il, int bcol);
    wr(0, {16'(vt), 16'(ht)});
    wr(1, {16'(hbs), 16'(hbe)});
    wr(2, {16'(vbs), 16'(vbe)});
    wr(3, {2'b0, 10'(md), 10'(hgt), 10'(w)});
    wr(4, 32'(whs));
    wr(5, {16'(vs0), 16'(vs1)});
    wr(6, 32'(b0));
    wr(7, 32'(b1));
    wr(8, {28'd0, blank, 2'b0, lr});
    wr(9, {8'd0, x2, 19'd0, 2'(bpc), ld, en});
    wr(10, {23'd0, vid, 3'd0, il, 4'd0});
    wr(11, 32'(bcol));
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "hsync", 32'(hsync), 0);
    chk("R1", "vsync", 32'(vsync), 0);
    chk("R1", "in_border", 32'(in_border), 0);
    chk("R1", "fetch_req", 32'(fetch_req), 0);
    chk("R1", "rgb", 32'(rgb), 0);
    repeat (4) tick();
    // directed A: 16 bpp, plain progressive
    cfg(48, 24, 8, 44, 2, 22, 3, 5, 1, 12, 4, 5, 'h100, 'h800,
        0, 0, 1, 0, 1, 0, 1, 0, 'h123456);
    while (mv != 10) tick();
    chk("R4", "in_border before field end", 32'(in_border), 0);
    next_frame();
    while (!(mv == 10 && mh == 20)) tick();
    chk("R4", "in_border after field end", 32'(in_border), 1);
    next_frame(); next_frame();
    // directed B: interlace, line doubling, low resolution, 32 bpp
    cfg(56, 26, 4, 52, 1, 25, 3, 3, 5, 10, 3, 4, 'h2000, 'h2004,
        1, 0, 1, 1, 3, 1, 1, 1, 'hABCDEF);
    repeat (4) next_frame();
    // directed C: blank over 8 bpp low resolution
    cfg(48, 24, 2, 46, 1, 23, 3, 4, 2, 10, 3, 3, 'h40, 'h80,
        1, 1, 1, 0, 0, 0, 1, 0, 'h00FF00);
    repeat (2) next_frame();
    // directed D: video disabled
    cfg(48, 24, 2, 46, 1, 23, 3, 4, 2, 10, 3, 3, 'h40, 'h80,
        0, 0, 1, 0, 0, 0, 0, 0, 'h0000FF);
    repeat (2) next_frame();
    // random configurations
    for (int k = 0; k < 24; k++) begin
      int ht, vt;
      ht = 40 + int'($urandom % 24);
      vt = 16 + int'($urandom % 15);
      cfg(ht, vt, int'($urandom % 8), ht - int'($urandom % 6),
          int'($urandom % 3), vt - int'($urandom % 3),
          int'($urandom % 4), int'($urandom % 5), int'($urandom % 8),
          1 + int'($urandom % 10), int'($urandom % 6), 1 + int'($urandom % 6),
          int'($urandom & 32'hFFFFFF), int'($urandom & 32'hFFFFFF),
          1'($urandom), ($urandom % 5) == 0, ($urandom % 6) != 0, 1'($urandom),
          int'($urandom % 4), 1'($urandom), ($urandom % 8) != 0, 1'($urandom),
          int'($urandom));
      repeat (2) next_frame();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule